// File: doc/BRIEF.md
# Hashed Page Table Chain Walker

This block translates a logical page number into a physical address by searching a hashed page table. The page number is folded into a bucket index. The bucket-head memory returns a pointer to the first element of that bucket's chain. The block then reads the chain from an element memory one element at a time. For each element it compares the stored page number with the requested one. On a match, the element's frame number is joined with the request offset to form the physical address. On a mismatch, the walk moves on through the element's link field.

Both memories sit outside the block. Each has a single synchronous read port with one cycle of latency. The surrounding system fills the memories; this block only reads them. Only one lookup runs at a time. A new request is taken only while the block is idle. A walk ends in one of three ways: a hit, a terminating link, or a hop budget being used up. The hop budget protects the block against a damaged list that loops back on itself.

Top module: `hpt_chain_lookup`

## Requirements
- R1: On accepting a request, the block presents the bucket index `req_page[9:0] ^ req_page[19:10]` on `head_raddr`, starting from the clock edge that accepts the request.
- R2: If the bucket head read back is all ones (8'hFF, the null link), the lookup completes as a miss. `done` is high in the cycle after the 2nd clock edge following acceptance.
- R3: If the first element's page field equals the requested page, the lookup is a hit. `phys_addr` is then `{frame, offset}` and `done` follows the 4th edge after acceptance. The element word is laid out as page in bits [47:28], frame in bits [27:8] and next link in bits [7:0].
- R4: On a tag mismatch, the block reads the element named by the next link and compares again. A hit at the k-th element of a chain completes after edge 2+2k.
- R5: A mismatching element whose next link is all ones ends the walk as a miss after edge 2+2k, where k is the number of elements examined.
- R6: At most 64 elements are examined. If the 64th element mismatches, the walk ends as a miss after edge 130, even when the list continues or loops. A match at the 64th element is still a hit.
- R7: While `busy` is high, `req_valid` is ignored. The running lookup's result is unchanged, and no extra completion follows.
- R8: After reset, `busy`, `done`, `hit`, `miss` and `phys_addr` are all zero.
- R9: `done` is a single-cycle pulse, and exactly one of `hit`/`miss` is set with it. `busy` drops in the same cycle that `done` rises. On a miss, `phys_addr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request, taken when idle |
| req_page | input | 20 | Logical page number |
| req_offset | input | 12 | Byte offset within the page |
| busy | output | 1 | Lookup in progress |
| head_raddr | output | 10 | Bucket-head memory read address |
| head_rdata | input | 8 | Bucket-head memory read data (first element pointer) |
| elem_raddr | output | 8 | Element memory read address |
| elem_rdata | input | 48 | Element memory read data {page, frame, next} |
| done | output | 1 | Lookup complete pulse |
| hit | output | 1 | Last lookup found the page |
| miss | output | 1 | Last lookup did not find the page |
| phys_addr | output | 32 | Physical address {frame, offset} |

## Verification
Each lookup's completion cycle is fixed by the number of elements examined. Because of this, a corrupted state register, a lost link or a miscounted hop shows at the ports as `done` rising on the wrong edge. The error appears within two cycles of the step that went astray, not only through a wrong final address. The bench walks the same memory contents behaviourally and predicts that edge. It then compares `busy` and `done` on every cycle of every walk. The walks include an empty bucket, a three-element chain, a two-element cycle and a 65-element chain straddling the hop budget. A request injected mid-walk would, if accepted, corrupt the latched page and change the result or add a second pulse.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

  // Walk controller states
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_HREQ  = 3'd1,
    S_HCHK  = 3'd2,
    S_EREQ  = 3'd3,
    S_ECHK  = 3'd4
  } walk_state_t;

endpackage

// File: rtl/hpt_bucket_hash.sv
module hpt_bucket_hash #(
  parameter int PN_W   = 20,
  parameter int HASH_W = 10
) (
  input  logic [PN_W-1:0]   page,
  output logic [HASH_W-1:0] bucket
);
  localparam int NCH = (PN_W + HASH_W - 1) / HASH_W;

  logic [NCH*HASH_W-1:0] padded;
  logic [HASH_W-1:0]     fold [NCH];

  always_comb begin
    padded = '0;
    padded[PN_W-1:0] = page;
  end

  // XOR-fold the page number into HASH_W-bit chunks
  generate
    for (genvar c = 0; c < NCH; c++) begin : g_fold
      if (c == 0) begin : g_first
        assign fold[c] = padded[HASH_W-1:0];
      end else begin : g_next
        assign fold[c] = fold[c-1] ^ padded[c*HASH_W +: HASH_W];
      end
    end
  endgenerate

  assign bucket = fold[NCH-1];
endmodule

// File: rtl/hpt_hop_counter.sv
module hpt_hop_counter #(
  parameter int MAX_HOPS = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic load_first,
  input  logic step,
  output logic at_limit
);
  localparam int CW = $clog2(MAX_HOPS + 1);

  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (rst)             count <= '0;
    else if (load_first) count <= CW'(1);
    else if (step)       count <= count + CW'(1);
  end

  assign at_limit = (count == CW'(MAX_HOPS));

  // R6: the element count never passes the hop budget
  a_r6_hops_bounded: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(MAX_HOPS));

  // R6: no step is taken once the budget is reached
  a_r6_no_step_at_limit: assert property (@(posedge clk) disable iff (rst)
    at_limit |-> !step);
endmodule

// File: rtl/hpt_elem_match.sv
module hpt_elem_match #(
  parameter int PN_W    = 20,
  parameter int FRAME_W = 20,
  parameter int PTR_W   = 8,
  parameter int OFF_W   = 12
) (
  input  logic [PN_W+FRAME_W+PTR_W-1:0] elem,
  input  logic [PN_W-1:0]               page,
  input  logic [OFF_W-1:0]              offset,
  output logic                          tag_hit,
  output logic [PTR_W-1:0]              next_ptr,
  output logic                          next_null,
  output logic [FRAME_W+OFF_W-1:0]      phys
);
  logic [PN_W-1:0]    e_page;
  logic [FRAME_W-1:0] e_frame;

  assign {e_page, e_frame, next_ptr} = elem;
  assign tag_hit   = (e_page == page);
  assign next_null = (next_ptr == {PTR_W{1'b1}});
  assign phys      = {e_frame, offset};
endmodule

// File: rtl/hpt_chain_lookup.sv
module hpt_chain_lookup #(
  parameter int PN_W     = 20,
  parameter int OFF_W    = 12,
  parameter int HASH_W   = 10,
  parameter int FRAME_W  = 20,
  parameter int PTR_W    = 8,
  parameter int MAX_HOPS = 64,
  localparam int ELEM_W  = PN_W + FRAME_W + PTR_W,
  localparam int PA_W    = FRAME_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [PN_W-1:0]   req_page,
  input  logic [OFF_W-1:0]  req_offset,
  output logic              busy,
  output logic [HASH_W-1:0] head_raddr,
  input  logic [PTR_W-1:0]  head_rdata,
  output logic [PTR_W-1:0]  elem_raddr,
  input  logic [ELEM_W-1:0] elem_rdata,
  output logic              done,
  output logic              hit,
  output logic              miss,
  output logic [PA_W-1:0]   phys_addr
);
  import hpt_pkg::*;

  localparam logic [PTR_W-1:0] NULL_PTR = {PTR_W{1'b1}};

  walk_state_t       state;
  logic [PN_W-1:0]   page_q;
  logic [OFF_W-1:0]  off_q;
  logic [HASH_W-1:0] bucket;
  logic              tag_hit, next_null, at_limit;
  logic [PTR_W-1:0]  next_ptr;
  logic [PA_W-1:0]   cand_phys;
  logic              head_null, load_first, step;

  hpt_bucket_hash #(.PN_W(PN_W), .HASH_W(HASH_W)) u_hash (
    .page   (req_page),
    .bucket (bucket)
  );

  hpt_elem_match #(.PN_W(PN_W), .FRAME_W(FRAME_W), .PTR_W(PTR_W), .OFF_W(OFF_W)) u_match (
    .elem      (elem_rdata),
    .page      (page_q),
    .offset    (off_q),
    .tag_hit   (tag_hit),
    .next_ptr  (next_ptr),
    .next_null (next_null),
    .phys      (cand_phys)
  );

  assign head_null  = (head_rdata == NULL_PTR);
  assign load_first = (state == S_HCHK) && !head_null;
  assign step       = (state == S_ECHK) && !tag_hit && !next_null && !at_limit;

  hpt_hop_counter #(.MAX_HOPS(MAX_HOPS)) u_hops (
    .clk        (clk),
    .rst        (rst),
    .load_first (load_first),
    .step       (step),
    .at_limit   (at_limit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      page_q     <= '0;
      off_q      <= '0;
      head_raddr <= '0;
      elem_raddr <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      hit        <= 1'b0;
      miss       <= 1'b0;
      phys_addr  <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            page_q     <= req_page;
            off_q      <= req_offset;
            head_raddr <= bucket;
            busy       <= 1'b1;
            state      <= S_HREQ;
          end
        end
        S_HREQ: state <= S_HCHK;
        S_HCHK: begin
          if (head_null) begin
            busy      <= 1'b0;
            done      <= 1'b1;
            hit       <= 1'b0;
            miss      <= 1'b1;
            phys_addr <= '0;
            state     <= S_IDLE;
          end else begin
            elem_raddr <= head_rdata;
            state      <= S_EREQ;
          end
        end
        S_EREQ: state <= S_ECHK;
        S_ECHK: begin
          if (tag_hit) begin
            busy      <= 1'b0;
            done      <= 1'b1;
            hit       <= 1'b1;
            miss      <= 1'b0;
            phys_addr <= cand_phys;
            state     <= S_IDLE;
          end else if (next_null || at_limit) begin
            busy      <= 1'b0;
            done      <= 1'b1;
            hit       <= 1'b0;
            miss      <= 1'b1;
            phys_addr <= '0;
            state     <= S_IDLE;
          end else begin
            elem_raddr <= next_ptr;
            state      <= S_EREQ;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R9: completion is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: exactly one outcome accompanies completion
  a_r9_one_outcome: assert property (@(posedge clk) disable iff (rst)
    done |-> (hit != miss));

  // R9: busy falls exactly when done rises
  a_r9_busy_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R7: a request seen while busy leaves the latched page untouched
  a_r7_ignore_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && req_valid) |=> $stable(page_q));

  // R3: a hit carries the latched offset in the low bits
  a_r3_offset_kept: assert property (@(posedge clk) disable iff (rst)
    (done && hit) |-> (phys_addr[OFF_W-1:0] == off_q));

  // R9: a miss reports a zero address
  a_r9_miss_zero: assert property (@(posedge clk) disable iff (rst)
    (done && miss) |-> (phys_addr == '0));
endmodule

// File: tb/tb_hpt_chain_lookup.sv
`timescale 1ns/1ps
module tb_hpt_chain_lookup;
  localparam logic [7:0] NUL = 8'hFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [19:0] req_page = '0;
  logic [11:0] req_offset = '0;
  logic        busy, done, hit, miss;
  logic [9:0]  head_raddr;
  logic [7:0]  head_rdata, elem_raddr;
  logic [47:0] elem_rdata;
  logic [31:0] phys_addr;

  logic [7:0]  head_mem [1024];
  logic [47:0] elem_mem [256];

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  hpt_chain_lookup dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_page(req_page),
    .req_offset(req_offset), .busy(busy), .head_raddr(head_raddr),
    .head_rdata(head_rdata), .elem_raddr(elem_raddr), .elem_rdata(elem_rdata),
    .done(done), .hit(hit), .miss(miss), .phys_addr(phys_addr)
  );

  // Synchronous single-port read memories, one cycle latency
  always_ff @(posedge clk) begin
    head_rdata <= head_mem[head_raddr];
    elem_rdata <= elem_mem[elem_raddr];
  end

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] fold(logic [19:0] p);
    return p[9:0] ^ p[19:10];
  endfunction

  function automatic logic [19:0] mkpage(logic [9:0] bkt, logic [9:0] hi);
    return {hi, hi ^ bkt};
  endfunction

  // Behavioural walk of the table contents: outcome and completion edge
  task automatic predict(input logic [19:0] p, output bit ehit,
                         output logic [19:0] eframe, output int ecyc);
    int n = 0;
    logic [7:0] ptr = head_mem[fold(p)];
    ehit = 0; eframe = '0;
    if (ptr == NUL) begin ecyc = 2; return; end
    forever begin
      n++;
      if (elem_mem[ptr][47:28] == p) begin
        ehit = 1; eframe = elem_mem[ptr][27:8]; break;
      end
      if (elem_mem[ptr][7:0] == NUL || n == 64) break;
      ptr = elem_mem[ptr][7:0];
    end
    ecyc = 2 + 2 * n;
  endtask

  task automatic lookup(string tag, logic [19:0] p, logic [11:0] off,
                        bit inject);
    bit ehit; logic [19:0] efr; int ecyc;
    predict(p, ehit, efr, ecyc);
    @(negedge clk);
    req_valid = 1; req_page = p; req_offset = off;
    @(posedge clk);
    for (int k = 0; k <= ecyc; k++) begin
      @(negedge clk);
      req_valid = 0;
      if (inject && k == 1) begin
        req_valid = 1; req_page = p ^ 20'h5A5A5; req_offset = ~off;
      end
      if (k == 0) check({tag, " R1 head_raddr"}, 64'(head_raddr), 64'(fold(p)));
      check({tag, " R9 busy"}, 64'(busy), 64'(k < ecyc));
      check({tag, " done timing"}, 64'(done), 64'(k == ecyc));
    end
    req_valid = 0;
    check({tag, " hit"}, 64'(hit), 64'(ehit));
    check({tag, " R9 miss"}, 64'(miss), 64'(!ehit));
    check({tag, " phys"}, 64'(phys_addr), ehit ? 64'({efr, off}) : 64'd0);
    if (inject) begin
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        check({tag, " R7 no extra done"}, 64'(done), 64'd0);
      end
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    for (int i = 0; i < 1024; i++) head_mem[i] = NUL;
    for (int i = 0; i < 256; i++) elem_mem[i] = {20'hFFFFF, 20'h0, NUL};
    // single element
    elem_mem[0] = {mkpage(10'h30D, 10'h048), 20'hABCDE, NUL};
    head_mem[10'h30D] = 8'd0;
    // three-element chain
    elem_mem[1] = {mkpage(10'h055, 10'd1), 20'h11111, 8'd2};
    elem_mem[2] = {mkpage(10'h055, 10'd2), 20'h22222, 8'd3};
    elem_mem[3] = {mkpage(10'h055, 10'd3), 20'h33333, NUL};
    head_mem[10'h055] = 8'd1;
    // cyclic pair
    elem_mem[10] = {mkpage(10'h2AA, 10'd1), 20'h0AAAA, 8'd11};
    elem_mem[11] = {mkpage(10'h2AA, 10'd2), 20'h0BBBB, 8'd10};
    head_mem[10'h2AA] = 8'd10;
    // 65-element chain
    for (int i = 100; i <= 164; i++)
      elem_mem[i] = {mkpage(10'h111, 10'(i - 99)), 20'(i), (i == 164) ? NUL : 8'(i + 1)};
    head_mem[10'h111] = 8'd100;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 busy", 64'(busy), 0);
    check("R8 done", 64'(done), 0);
    check("R8 hit", 64'(hit), 0);
    check("R8 miss", 64'(miss), 0);
    check("R8 phys", 64'(phys_addr), 0);
    rst = 0;

    lookup("R3 first", mkpage(10'h30D, 10'h048), 12'h123, 0);
    lookup("R2 empty", mkpage(10'h3FF, 10'h001), 12'h456, 0);
    lookup("R4 third", mkpage(10'h055, 10'd3), 12'hFED, 0);
    lookup("R4 head", mkpage(10'h055, 10'd1), 12'h001, 0);
    lookup("R5 end", mkpage(10'h055, 10'd7), 12'h777, 0);
    lookup("R6 cycle", mkpage(10'h2AA, 10'd9), 12'h0F0, 0);
    lookup("R6 hit64", mkpage(10'h111, 10'd64), 12'hABC, 0);
    lookup("R6 miss65", mkpage(10'h111, 10'd65), 12'hABC, 0);
    lookup("R7 inject", mkpage(10'h055, 10'd2), 12'h3C3, 1);
    lookup("R1 again", mkpage(10'h30D, 10'h048), 12'hFFF, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule